// File: doc/BRIEF.md
# ALU Result Flags and Control Status Register

This block is the flag word of a processor core. Each cycle that the execute stage presents a valid ALU result, the block derives six condition flags from that result and from a few side signals of the adder: the carry out of the top bit, the carry out of bit 3, and the two operand sign bits. It then writes back only the flags that the operation class is allowed to touch. Addition and subtraction refresh all six flags. A logical operation refreshes zero, sign and parity, forces carry and overflow low, and keeps the nibble carry. A fourth class code leaves every flag alone.

Next to the condition flags, the word holds three control bits: interrupt enable, single-step trap and string direction. It also holds a sticky saturation bit. The control bits move only through set and clear masks, which take effect when a privileged-mode input is high. The saturation bit latches whenever the ALU reports a signed saturation event and stays set until a privileged clear arrives. The assembled word is always visible on one output, and its unused bits are zero.

Top module: `alu_status_reg`

## Requirements
- R1: After reset every bit of the flag word is 0.
- R2: In a cycle with the result strobe low, no condition flag changes, whatever the other ALU inputs carry.
- R3: On an add, subtract or logical result, the zero flag becomes 1 exactly when the whole result is 0.
- R4: On an add, subtract or logical result, the sign flag takes the result's most significant bit.
- R5: The carry flag takes the carry-out input on add (class 0). It takes the inverted carry-out input, that is the borrow, on subtract (class 1). The ALU computes subtraction as a + ~b + 1.
- R6: The overflow flag is set on an add when both operand signs are equal and the result sign differs. It is set on a subtract when the operand signs differ and the result sign differs from operand a. Otherwise it is cleared.
- R7: The auxiliary flag takes the bit-3 carry input on add and its inverse on subtract.
- R8: The parity flag is 1 when the low 8 bits of the result contain an even number of ones.
- R9: A logical result (class 2) forces carry and overflow to 0 and leaves the auxiliary flag unchanged. Class 3 changes no condition flag.
- R10: The word layout is: carry bit 0, parity bit 2, auxiliary bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt enable bit 9, direction bit 10, overflow bit 11, saturation bit 12. All other bits read 0.
- R11: Control masks use bit 0 for interrupt enable, bit 1 for trap, bit 2 for direction and bit 3 for saturation. A set or clear takes effect only while the privileged input is high, and clear wins over set. Without privilege the masks are ignored.
- R12: Interrupt enable, trap and direction never change as a consequence of ALU results.
- R13: The saturation bit is set by a saturation event that arrives with a valid result. It stays set until a privileged clear, an event in the same cycle wins over the clear, and a set mask on bit 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_vld_i | input | 1 | ALU result strobe |
| op_cls_i | input | 2 | Operation class: 0 add, 1 subtract, 2 logical, 3 no flag update |
| res_i | input | DATA_W | ALU result |
| co_i | input | 1 | Carry out of the most significant bit |
| c3_i | input | 1 | Carry out of bit 3 |
| sa_i | input | 1 | Sign bit of operand a |
| sb_i | input | 1 | Sign bit of operand b |
| sat_evt_i | input | 1 | Signed saturation event from the ALU |
| priv_i | input | 1 | Privileged mode |
| ctl_set_i | input | 4 | Control bit set mask |
| ctl_clr_i | input | 4 | Control bit clear mask |
| flags_o | output | FLAG_W | Assembled flag word |

## Verification
Every bit of state drives the output word directly through one register, so a wrong update mask, a wrong polarity on a subtract or a misplaced bit appears on flags_o in the cycle right after the offending result. There is no delay beyond that. A control or saturation bit that leaks from the ALU path, or that ignores privilege, behaves differently: it stays wrong in the word until a legal command overwrites it, so a single bad update shows up in every later comparison. The sweeps therefore compare the whole word after every operation, rather than only the flag that the operation targets.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_SUB   = 2'd1,
        OP_LOGIC = 2'd2,
        OP_NONE  = 2'd3
    } op_cls_e;

    // bit positions in the flag word
    localparam int B_CF  = 0;
    localparam int B_PF  = 2;
    localparam int B_AF  = 4;
    localparam int B_ZF  = 6;
    localparam int B_SF  = 7;
    localparam int B_TF  = 8;
    localparam int B_IE  = 9;
    localparam int B_DF  = 10;
    localparam int B_OF  = 11;
    localparam int B_SAT = 12;
    localparam int WORD_MIN = B_SAT + 1;

    // control mask bit indices
    localparam int CTL_N  = 4;
    localparam int CI_IE  = 0;
    localparam int CI_TF  = 1;
    localparam int CI_DF  = 2;
    localparam int CI_SAT = 3;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } arith_t;

    typedef struct packed {
        logic ie;
        logic tf;
        logic df;
        logic sat;
    } ctl_t;

    typedef struct packed {
        arith_t ar;
        ctl_t   ctl;
    } sreg_t;

endpackage

// File: rtl/sr_flag_eval.sv
module sr_flag_eval
    import sr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_cls_e           op_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              co_i,
    input  logic              c3_i,
    input  logic              sa_i,
    input  logic              sb_i,
    output arith_t            cand_o
);
    localparam int MSB   = DATA_W - 1;
    localparam int PAR_W = (DATA_W < 8) ? DATA_W : 8;

    logic par_even;

    generate
        if (DATA_W > PAR_W) begin : g_wide
            assign par_even = ~^res_i[PAR_W-1:0];
        end else begin : g_narrow
            assign par_even = ~^res_i;
        end
    endgenerate

    logic is_sub;
    logic is_logic;
    logic same_sign;
    logic res_flip;

    always_comb begin
        is_sub    = (op_i == OP_SUB);
        is_logic  = (op_i == OP_LOGIC);
        same_sign = (sa_i == sb_i);
        res_flip  = (res_i[MSB] != sa_i);

        cand_o.zf = (res_i == '0);
        cand_o.sf = res_i[MSB];
        cand_o.pf = par_even;
        cand_o.af = is_sub ? ~c3_i : c3_i;

        if (is_logic) begin
            cand_o.cf = 1'b0;
            cand_o.of = 1'b0;
        end else if (is_sub) begin
            cand_o.cf = ~co_i;
            cand_o.of = ~same_sign & res_flip;
        end else begin
            cand_o.cf = co_i;
            cand_o.of = same_sign & res_flip;
        end
    end

endmodule

// File: rtl/sr_class_mask.sv
module sr_class_mask
    import sr_pkg::*;
(
    input  op_cls_e op_i,
    output arith_t  mask_o
);
    always_comb begin
        mask_o = '0;
        unique case (op_i)
            OP_ADD, OP_SUB: mask_o = '1;
            OP_LOGIC: begin
                mask_o    = '1;
                mask_o.af = 1'b0;
            end
            default: mask_o = '0;
        endcase
    end
endmodule

// File: rtl/sr_ctl_update.sv
module sr_ctl_update
    import sr_pkg::*;
(
    input  ctl_t             ctl_q_i,
    input  logic             priv_i,
    input  logic [CTL_N-1:0] set_i,
    input  logic [CTL_N-1:0] clr_i,
    input  logic             sat_hit_i,
    output ctl_t             ctl_d_o
);
    logic [CTL_N-1:0] cur;
    logic [CTL_N-1:0] nxt;
    logic [CTL_N-1:0] set_ok;

    always_comb begin
        cur            = {ctl_q_i.sat, ctl_q_i.df, ctl_q_i.tf, ctl_q_i.ie};
        set_ok         = set_i;
        set_ok[CI_SAT] = 1'b0;
    end

    generate
        for (genvar i = 0; i < CTL_N; i++) begin : g_bit
            always_comb begin
                nxt[i] = cur[i];
                if (priv_i) begin
                    if (clr_i[i])       nxt[i] = 1'b0;
                    else if (set_ok[i]) nxt[i] = 1'b1;
                end
                if (i == CI_SAT && sat_hit_i) nxt[i] = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        ctl_d_o.ie  = nxt[CI_IE];
        ctl_d_o.tf  = nxt[CI_TF];
        ctl_d_o.df  = nxt[CI_DF];
        ctl_d_o.sat = nxt[CI_SAT];
    end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
    import sr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FLAG_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              res_vld_i,
    input  logic [1:0]        op_cls_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              co_i,
    input  logic              c3_i,
    input  logic              sa_i,
    input  logic              sb_i,
    input  logic              sat_evt_i,
    input  logic              priv_i,
    input  logic [3:0]        ctl_set_i,
    input  logic [3:0]        ctl_clr_i,
    output logic [FLAG_W-1:0] flags_o
);
    op_cls_e op;
    arith_t  cand;
    arith_t  mask;
    ctl_t    ctl_nxt;
    sreg_t   st_d;
    sreg_t   st_q;

    assign op = op_cls_e'(op_cls_i);

    sr_flag_eval #(.DATA_W(DATA_W)) u_eval (
        .op_i   (op),
        .res_i  (res_i),
        .co_i   (co_i),
        .c3_i   (c3_i),
        .sa_i   (sa_i),
        .sb_i   (sb_i),
        .cand_o (cand)
    );

    sr_class_mask u_mask (
        .op_i   (op),
        .mask_o (mask)
    );

    sr_ctl_update u_ctl (
        .ctl_q_i   (st_q.ctl),
        .priv_i    (priv_i),
        .set_i     (ctl_set_i),
        .clr_i     (ctl_clr_i),
        .sat_hit_i (res_vld_i & sat_evt_i),
        .ctl_d_o   (ctl_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ctl = ctl_nxt;
        if (res_vld_i) begin
            if (mask.cf) st_d.ar.cf = cand.cf;
            if (mask.pf) st_d.ar.pf = cand.pf;
            if (mask.af) st_d.ar.af = cand.af;
            if (mask.zf) st_d.ar.zf = cand.zf;
            if (mask.sf) st_d.ar.sf = cand.sf;
            if (mask.of) st_d.ar.of = cand.of;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        flags_o        = '0;
        flags_o[B_CF]  = st_q.ar.cf;
        flags_o[B_PF]  = st_q.ar.pf;
        flags_o[B_AF]  = st_q.ar.af;
        flags_o[B_ZF]  = st_q.ar.zf;
        flags_o[B_SF]  = st_q.ar.sf;
        flags_o[B_TF]  = st_q.ctl.tf;
        flags_o[B_IE]  = st_q.ctl.ie;
        flags_o[B_DF]  = st_q.ctl.df;
        flags_o[B_OF]  = st_q.ar.of;
        flags_o[B_SAT] = st_q.ctl.sat;
    end

endmodule

// File: rtl/sr_status_chk.sv
module sr_status_chk
    import sr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FLAG_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              res_vld_i,
    input logic [1:0]        op_cls_i,
    input logic [DATA_W-1:0] res_i,
    input logic              co_i,
    input logic              c3_i,
    input logic              sa_i,
    input logic              sb_i,
    input logic              sat_evt_i,
    input logic              priv_i,
    input logic [3:0]        ctl_set_i,
    input logic [3:0]        ctl_clr_i,
    input logic [FLAG_W-1:0] flags_o
);
    localparam logic [FLAG_W-1:0] USED_M =
        (FLAG_W'(1) << B_CF) | (FLAG_W'(1) << B_PF) | (FLAG_W'(1) << B_AF) |
        (FLAG_W'(1) << B_ZF) | (FLAG_W'(1) << B_SF) | (FLAG_W'(1) << B_TF) |
        (FLAG_W'(1) << B_IE) | (FLAG_W'(1) << B_DF) | (FLAG_W'(1) << B_OF) |
        (FLAG_W'(1) << B_SAT);
    localparam logic [FLAG_W-1:0] COND_M =
        (FLAG_W'(1) << B_CF) | (FLAG_W'(1) << B_PF) | (FLAG_W'(1) << B_AF) |
        (FLAG_W'(1) << B_ZF) | (FLAG_W'(1) << B_SF) | (FLAG_W'(1) << B_OF);

    logic upd;
    assign upd = res_vld_i && (op_cls_i != 2'd3);

    // R10
    rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_o & ~USED_M) == '0);

    // R2
    hold_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !res_vld_i |=> (flags_o & COND_M) == ($past(flags_o) & COND_M));

    // R3
    zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd |=> flags_o[B_ZF] == ($past(res_i) == '0));

    // R4
    sign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd |=> flags_o[B_SF] == $past(res_i[DATA_W-1]));

    // R9
    logic_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_vld_i && op_cls_i == 2'd2) |=> !flags_o[B_CF] && !flags_o[B_OF]);

    // R9
    logic_af_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_vld_i && op_cls_i == 2'd2) |=> $stable(flags_o[B_AF]));

    // R11
    unpriv_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !priv_i |=> $stable(flags_o[B_IE]) && $stable(flags_o[B_TF]) && $stable(flags_o[B_DF]));

    // R13
    sat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_o[B_SAT] && !(priv_i && ctl_clr_i[CI_SAT])) |=> flags_o[B_SAT]);

    // R13
    sat_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_vld_i && sat_evt_i) |=> flags_o[B_SAT]);

endmodule

bind alu_status_reg sr_status_chk #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/alu_status_reg_bench.sv
module alu_status_reg_bench;
    localparam int DW = 8;
    localparam int FW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          res_vld = 1'b0;
    logic [1:0]    op_cls = 2'd0;
    logic [DW-1:0] res = '0;
    logic          co = 1'b0, c3 = 1'b0, sa = 1'b0, sb = 1'b0;
    logic          sat_evt = 1'b0, priv = 1'b0;
    logic [3:0]    cset = '0, cclr = '0;
    logic [FW-1:0] flags;

    int checks = 0;
    int fails  = 0;

    // bench model
    bit m_cf, m_pf, m_af, m_zf, m_sf, m_of, m_tf, m_ie, m_df, m_sat;

    always #4 clk = ~clk;

    alu_status_reg #(.DATA_W(DW), .FLAG_W(FW)) u_alu_status_reg (
        .clk_i(clk), .rst_ni(rst_n), .res_vld_i(res_vld), .op_cls_i(op_cls),
        .res_i(res), .co_i(co), .c3_i(c3), .sa_i(sa), .sb_i(sb),
        .sat_evt_i(sat_evt), .priv_i(priv), .ctl_set_i(cset), .ctl_clr_i(cclr),
        .flags_o(flags)
    );

    function automatic logic [FW-1:0] model_word();
        logic [FW-1:0] w = '0;
        w[0] = m_cf; w[2] = m_pf; w[4] = m_af; w[6] = m_zf; w[7] = m_sf;
        w[8] = m_tf; w[9] = m_ie; w[10] = m_df; w[11] = m_of; w[12] = m_sat;
        return w;
    endfunction

    task automatic check(input string tag);
        logic [FW-1:0] e = model_word();
        checks++;
        if (flags !== e) begin
            fails++;
            $display("FAIL %s: flags=%h expected=%h", tag, flags, e);
        end
    endtask

    task automatic set_res_flags(input int r);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        m_zf = ((r & 255) == 0);
        m_sf = ((r >> 7) & 1) != 0;
        m_pf = (ones % 2) == 0;
    endtask

    // arithmetic op; we are at a negedge on entry and on exit
    task automatic arith(input bit is_sub, input int a, input int b, input bit sev, input string tag);
        int r, sr, as, bs;
        as = (a > 127) ? a - 256 : a;
        bs = (b > 127) ? b - 256 : b;
        if (!is_sub) begin
            r    = a + b;
            m_cf = r > 255;
            m_af = ((a & 15) + (b & 15)) > 15;
            sr   = as + bs;
            co   = m_cf;
            c3   = m_af;
        end else begin
            r    = a - b;
            m_cf = a < b;
            m_af = (a & 15) < (b & 15);
            sr   = as - bs;
            co   = !m_cf;
            c3   = !m_af;
        end
        m_of = (sr > 127) || (sr < -128);
        set_res_flags(r);
        if (sev) m_sat = 1'b1;
        res     = DW'(r & 255);
        sa      = a[7];
        sb      = b[7];
        op_cls  = is_sub ? 2'd1 : 2'd0;
        sat_evt = sev;
        res_vld = 1'b1;
        @(negedge clk);
        check(tag);
        res_vld = 1'b0;
        sat_evt = 1'b0;
    endtask

    task automatic logic_op(input int r, input bit junk, input string tag);
        set_res_flags(r);
        m_cf = 1'b0;
        m_of = 1'b0;
        res = DW'(r & 255); co = junk; c3 = ~m_af; sa = junk; sb = ~junk;
        op_cls = 2'd2; res_vld = 1'b1;
        @(negedge clk);
        check(tag);
        res_vld = 1'b0;
    endtask

    task automatic ctl(input bit p, input logic [3:0] s, input logic [3:0] c, input string tag);
        if (p) begin
            m_ie = c[0] ? 1'b0 : (s[0] ? 1'b1 : m_ie);
            m_tf = c[1] ? 1'b0 : (s[1] ? 1'b1 : m_tf);
            m_df = c[2] ? 1'b0 : (s[2] ? 1'b1 : m_df);
            if (c[3]) m_sat = 1'b0;
        end
        priv = p; cset = s; cclr = c;
        @(negedge clk);
        check(tag);
        priv = 1'b0; cset = '0; cclr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word");

        // R11 unprivileged commands ignored
        ctl(1'b0, 4'hF, 4'h0, "R11 unpriv set");
        ctl(1'b1, 4'b0111, 4'h0, "R11 priv set");
        ctl(1'b0, 4'h0, 4'hF, "R11 unpriv clear");
        ctl(1'b1, 4'b0010, 4'b0010, "R11 clear beats set");
        ctl(1'b1, 4'b1000, 4'h0, "R13 set mask ignored");
        ctl(1'b1, 4'b0010, 4'h0, "R10 trap position");

        // R3 R4 R5 R6 R7 R8 R10 R12 sweeps: word compare includes control bits
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 3)
                arith(1'b0, a, b, 1'b0, "R3 R4 R5 R6 R7 R8 R12 add");
        for (int a = 0; a < 256; a++)
            for (int b = 1; b < 256; b += 3)
                arith(1'b1, a, b, 1'b0, "R3 R4 R5 R6 R7 R8 R12 sub");

        // R9 logical class
        arith(1'b0, 8'h0F, 8'h01, 1'b0, "R7 af set before logic");
        logic_op(8'h00, 1'b1, "R9 logic zero");
        logic_op(8'h81, 1'b1, "R9 logic neg odd");
        logic_op(8'h3C, 1'b0, "R9 logic even");
        arith(1'b0, 8'h01, 8'h01, 1'b0, "R7 af clear before logic");
        logic_op(8'hFF, 1'b1, "R9 logic af kept low");

        // R9 class 3: no update
        res = 8'h00; co = 1'b1; c3 = 1'b1; sa = 1'b0; sb = 1'b0;
        op_cls = 2'd3; res_vld = 1'b1;
        @(negedge clk);
        check("R9 class 3 no update");
        res_vld = 1'b0;

        // R2 strobe low with junk inputs
        for (int k = 0; k < 8; k++) begin
            res = DW'(k * 37); co = k[0]; c3 = k[1]; sa = k[2]; sb = ~k[0];
            op_cls = k[1:0];
            @(negedge clk);
            check("R2 hold without strobe");
        end

        // R13 sticky saturation
        sat_evt = 1'b1; res_vld = 1'b0;
        @(negedge clk);
        check("R13 event without strobe ignored");
        sat_evt = 1'b0;
        arith(1'b0, 8'h7F, 8'h01, 1'b1, "R13 sat set");
        arith(1'b0, 8'h01, 8'h01, 1'b0, "R13 sat held");
        ctl(1'b0, 4'h0, 4'h8, "R13 unpriv clear ignored");
        // event and privileged clear together: event wins
        priv = 1'b1; cclr = 4'h8;
        arith(1'b1, 8'h80, 8'h01, 1'b1, "R13 event beats clear");
        priv = 1'b0; cclr = 4'h0;
        ctl(1'b1, 4'h0, 4'h8, "R13 priv clear");
        ctl(1'b1, 4'h0, 4'b0111, "R11 priv clear all");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule